// File: doc/BRIEF.md
# Two-Digit BCD Counter with Programmable Modulus

This block counts events on a strobe line and presents the running total as two BCD digits. Each digit is kept as a one-bit divide-by-2 section in the low bit and a divide-by-5 section in the upper three bits. The divide-by-5 section moves forward whenever the low bit falls from 1 to 0. Together the two sections step through 0 to 9 in BCD. The tens digit is a copy of the same structure, and it moves forward only when the units digit rolls over.

Everything runs on one clock. A count event is a high-to-low transition of `cnt_strobe`, as seen at the clock. Instead of clocking the sections from one another, each section has its own enable. Two AND-gated control pairs force the count to a fixed value: a clear pair forces 00, and a nine pair forces the units digit to 9. The `MOD` parameter, from 1 to 100, truncates the count. The count runs from 0 to `MOD-1`, and the next event returns it to 00 with a one-cycle terminal pulse. The default of 53 gives a modulo-53 counter.

Top module: `bcd_mod_counter`

## Requirements
- R1: While `rst_n` is low, both digits are 0000 and `tc` is 0.
- R2: The count advances by exactly one for each high-to-low transition of `cnt_strobe` sampled at the clock. A strobe that stays high, stays low or rises leaves the digits unchanged.
- R3: The units digit runs 0,1,...,9 in BCD. Bit 0 toggles on every event, and bits 3..1 advance (0 to 4, then back to 0) only on events where bit 0 goes from 1 to 0.
- R4: The tens digit advances only on an event that takes the units digit from 9 to 0, so 09 is followed by 10.
- R5: When `clr_a` and `clr_b` are both high and the nine pair is not both high, the next clock sets both digits to 0000.
- R6: When `nine_a` and `nine_b` are both high, the next clock sets units to 1001 and tens to 0000, whatever the clear pair is doing.
- R7: A control pair with at least one input low has no effect, and counting proceeds normally.
- R8: On an event while the count is `MOD-1` (52 by default) or above, both digits return to 00. `tc` is high for exactly the one cycle that follows, and `tc` is 0 at all other times.
- R9: A strobe event that arrives while either control pair is fully asserted is discarded and is not counted later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_strobe | input | 1 | Count input; a falling transition is one event |
| clr_a | input | 1 | Clear pair, first input |
| clr_b | input | 1 | Clear pair, second input |
| nine_a | input | 1 | Nine pair, first input |
| nine_b | input | 1 | Nine pair, second input |
| ones | output | 4 | Units digit, BCD |
| tens | output | 4 | Tens digit, BCD |
| tc | output | 1 | One-cycle pulse when the count wraps to 00 |

## Verification
The assertions assume that `cnt_strobe` and both control pairs are synchronous to `clk`. They also assume that an event is always preceded by at least one clock with the strobe high, which keeps consecutive wraps at least two cycles apart. The stimulus changes every input only on the falling clock edge. Each strobe pulse is held high for one full cycle and then low for at least one. Control pairs are held for whole cycles.

// File: rtl/bcd_mod_counter.sv
module bcd_mod_counter #(
  parameter int MOD = 53
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt_strobe,
  input  logic       clr_a,
  input  logic       clr_b,
  input  logic       nine_a,
  input  logic       nine_b,
  output logic [3:0] ones,
  output logic [3:0] tens,
  output logic       tc
);
  localparam int       LAST   = MOD - 1;
  localparam logic [3:0] LAST_T = 4'(LAST / 10);
  localparam logic [3:0] LAST_U = 4'(LAST % 10);

  if ((MOD < 1) || (MOD > 100)) begin : g_bad_mod
    $error("MOD must lie in 1..100");
  end

  function automatic logic [2:0] next5(input logic [2:0] q);
    return (q == 3'd4) ? 3'd0 : q + 3'd1;
  endfunction

  logic       strobe_q;
  logic       u_b, t_b;
  logic [2:0] u_q5, t_q5;

  wire load9   = nine_a & nine_b;
  wire clear0  = clr_a & clr_b & ~load9;
  wire step    = strobe_q & ~cnt_strobe & ~load9 & ~clear0;
  wire at_last = (tens > LAST_T) || ((tens == LAST_T) && (ones >= LAST_U));
  wire wrap    = step & at_last;
  wire u5_en   = step & u_b;
  wire t_en    = u5_en & (u_q5 == 3'd4);
  wire t5_en   = t_en & t_b;

  assign ones = {u_q5, u_b};
  assign tens = {t_q5, t_b};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      u_b <= 1'b0; u_q5 <= 3'd0;
      t_b <= 1'b0; t_q5 <= 3'd0;
      tc  <= 1'b0;
    end else begin
      strobe_q <= cnt_strobe;
      if (load9) begin
        u_b <= 1'b1; u_q5 <= 3'd4;
        t_b <= 1'b0; t_q5 <= 3'd0;
        tc  <= 1'b0;
      end else if (clear0 || wrap) begin
        u_b <= 1'b0; u_q5 <= 3'd0;
        t_b <= 1'b0; t_q5 <= 3'd0;
        tc  <= wrap;
      end else begin
        tc <= 1'b0;
        if (step)  u_b  <= ~u_b;
        if (u5_en) u_q5 <= next5(u_q5);
        if (t_en)  t_b  <= ~t_b;
        if (t5_en) t_q5 <= next5(t_q5);
      end
    end
  end
endmodule

// File: rtl/bcd_mod_counter_chk.sv
module bcd_mod_counter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cnt_strobe,
  input logic       clr_a,
  input logic       clr_b,
  input logic       nine_a,
  input logic       nine_b,
  input logic [3:0] ones,
  input logic [3:0] tens,
  input logic       tc
);
  wire set_pair = nine_a && nine_b;
  wire clr_pair = clr_a && clr_b;

  assert_units_bcd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= 4'd9);

  assert_tens_bcd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tens <= 4'd9);

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pair && !set_pair) |=> (ones == 4'd0 && tens == 4'd0));

  assert_nine_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_pair |=> (ones == 4'd9 && tens == 4'd0));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_pair && !clr_pair && !($past(cnt_strobe) && !cnt_strobe))
      |=> $stable({tens, ones}));

  assert_tc_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (ones == 4'd0 && tens == 4'd0));

  assert_tc_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> !tc);
endmodule

bind bcd_mod_counter bcd_mod_counter_chk chk_i (.*);

// File: tb/bcd_mod_counter_tb_top.sv
module bcd_mod_counter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_strobe = 1'b0;
  logic clr_a = 1'b0, clr_b = 1'b0, nine_a = 1'b0, nine_b = 1'b0;
  logic [3:0] ones, tens;
  logic tc;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bcd_mod_counter #(.MOD(53)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_strobe(cnt_strobe),
    .clr_a(clr_a), .clr_b(clr_b), .nine_a(nine_a), .nine_b(nine_b),
    .ones(ones), .tens(tens), .tc(tc));

  // ctl = {clr_a, clr_b, nine_a, nine_b}, pulse, expected tens, ones
  typedef struct packed {
    logic [3:0] ctl;
    logic       pulse;
    logic [3:0] et;
    logic [3:0] eu;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{4'b0000, 1'b1, 4'd0, 4'd1},  // R2 R3
    '{4'b0000, 1'b1, 4'd0, 4'd2},  // R3
    '{4'b1000, 1'b1, 4'd0, 4'd3},  // R7 one clear input
    '{4'b0001, 1'b1, 4'd0, 4'd4},  // R7 one nine input
    '{4'b1100, 1'b0, 4'd0, 4'd0},  // R5
    '{4'b0011, 1'b0, 4'd0, 4'd9},  // R6
    '{4'b0000, 1'b1, 4'd1, 4'd0},  // R4
    '{4'b1111, 1'b0, 4'd0, 4'd9},  // R6 overrides clear
    '{4'b0000, 1'b1, 4'd1, 4'd0},  // R4
    '{4'b0000, 1'b1, 4'd1, 4'd1},  // R2
    '{4'b1100, 1'b1, 4'd0, 4'd0}   // R9 event discarded
  };

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual tens=%0d ones=%0d tc=%0b expected tens=%0d ones=%0d tc=%0b",
               req, act[8:5], act[4:1], act[0], exp[8:5], exp[4:1], exp[0]);
    end
  endtask

  task automatic pulse();
    cnt_strobe = 1'b1;
    @(negedge clk);
    cnt_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cnt_strobe = 1'b0;
    {clr_a, clr_b, nine_a, nine_b} = 4'b0000;
    repeat (2) @(negedge clk);
    check("R1", {tens, ones, tc}, 9'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    do_reset();

    foreach (VECS[i]) begin
      {clr_a, clr_b, nine_a, nine_b} = VECS[i].ctl;
      if (VECS[i].pulse) pulse();
      else @(negedge clk);
      check($sformatf("R2-table-%0d", i), {tens, ones, tc}, {VECS[i].et, VECS[i].eu, 1'b0});
      {clr_a, clr_b, nine_a, nine_b} = 4'b0000;
    end

    // R9: the event discarded above must not appear later
    @(negedge clk);
    check("R9", {tens, ones, tc}, 9'd0);

    // R2: strobe held high, no count
    cnt_strobe = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 high level", {tens, ones, tc}, 9'd0);
    cnt_strobe = 1'b0;
    @(negedge clk);
    check("R2 falling", {tens, ones, tc}, {4'd0, 4'd1, 1'b0});

    // R3 R4 R8: full walk from reset up to the wrap
    do_reset();
    for (int n = 1; n <= 52; n++) begin
      logic [3:0] pu;
      pu = ones;
      pulse();
      check("R3 R4 walk", {tens, ones, tc}, {4'(n / 10), 4'(n % 10), 1'b0});
      if (ones[0] == pu[0]) begin
        errors++;
        $display("FAIL R3 low bit did not toggle actual=%0b expected=%0b", ones[0], ~pu[0]);
      end
      checks++;
    end
    pulse();
    check("R8 wrap", {tens, ones, tc}, {4'd0, 4'd0, 1'b1});
    @(negedge clk);
    check("R8 tc one cycle", {tens, ones, tc}, 9'd0);
    pulse();
    check("R8 after wrap", {tens, ones, tc}, {4'd0, 4'd1, 1'b0});

    // R1 mid-count reset
    pulse();
    rst_n = 1'b0;
    #3;
    check("R1 async", {tens, ones, tc}, 9'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule